// File: doc/BRIEF.md
# Low-Power Auto-Reload Event Timer

This block raises wake-up events from a slow clock that stays on. A 16-bit up-counter is advanced by a power-of-two prescaler. It counts from zero up to a programmable reload value. On the tick where the count equals the reload value, the counter returns to zero and a sticky match flag is set. When the flag is enabled, it drives a level interrupt that stays high until software clears the flag. The counter needs no host activity, so the interrupt can wake a sleeping system.

Software drives the block through a small register bus. The bus is combinational on reads and takes one cycle per write. A typical sequence is: disable the timer, arm the interrupt, choose the divider, enable the timer, load the reload value, then issue a single-shot or continuous start. Write permission depends on the enable state. The interrupt enable can only be changed while the timer is off, and the reload value can only be changed while it is on. The counter therefore acts as an event generator, not as a free-running time base.

Top module: `evt_wake_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and `irq` is low.
- R2: After a start write, the first match occurs (reload+1)·2^N clock edges after the write edge, where N is the divider field at bits [11:9] of the configuration register (N = 0..7).
- R3: A continuous start (control bit 2 with bit 0 set) produces a match every (reload+1)·2^N edges, and the counter restarts from 0 each time.
- R4: A single-shot start (control bit 1 with bit 0 set) produces exactly one match and then stops the counter. If bits 1 and 2 are both set, continuous mode is used.
- R5: A write to the interrupt-enable register (bit 0) is ignored while the timer enable bit is set.
- R6: A write to the reload register is ignored while the timer enable bit is clear.
- R7: Writing 1 to bit 0 of the clear register clears the match flag, and writing 0 has no effect. If a match and a clear fall in the same cycle, the flag stays set.
- R8: `irq` is the match flag ANDed with the interrupt enable. It stays high until the flag is cleared.
- R9: A control write with bit 0 clear stops the counter and returns the counter and the prescaler to 0. The match flag is left unchanged.
- R10: The start bits are one-cycle commands and read back as 0. A start is ignored when the reload value is 0, or when the same write leaves the enable bit clear.
- R11: Register addresses: 0 control (enable bit 0), 1 configuration (divider [11:9]), 2 interrupt enable (bit 0), 3 clear (reads 0), 4 status (match flag bit 0), 5 reload (16 bits). Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level wake-up interrupt |

## Verification
A reload match that sets the flag and a software write that clears it can land on the same clock edge. The bench runs the counter in continuous mode with a short period. It measures the edge on which the flag first rises, then times the next clear write so that its write edge lands exactly on the following match. The status register is read afterwards, and the result is judged correct only if the flag is still set, because a set takes priority over a clear.

// File: rtl/ewt_pkg.sv
package ewt_pkg;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CFG    = 3'd1,
    A_IEN    = 3'd2,
    A_ICLR   = 3'd3,
    A_STAT   = 3'd4,
    A_RELOAD = 3'd5
  } ewt_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_ONCE_BIT = 1;
  localparam int CTRL_LOOP_BIT = 2;
  localparam int CFG_DIV_LSB   = 9;
  localparam int FLAG_BIT      = 0;

  // one-cycle commands decoded from a control write
  typedef struct packed {
    logic halt;
    logic once;
    logic loop;
  } ewt_cmd_t;

endpackage

// File: rtl/ewt_regs.sv
module ewt_regs
  import ewt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int PSC_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              match_evt_i,
  output ewt_cmd_t          cmd_o,
  output logic              en_o,
  output logic [PSC_W-1:0]  div_sel_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              irq_o
);

  logic              en_q;
  logic              ie_q;
  logic              flag_q;
  logic [PSC_W-1:0]  div_q;
  logic [CNT_W-1:0]  reload_q;

  logic              wr_any;
  logic              wr_ctrl, wr_cfg, wr_ien, wr_iclr, wr_reload;
  logic              clr_evt;

  function automatic logic addr_hit(input logic [ADDR_W-1:0] a, input ewt_addr_e r);
    return a == ADDR_W'(r);
  endfunction

  assign wr_any    = bus_sel & bus_wr;
  assign wr_ctrl   = wr_any & addr_hit(bus_addr, A_CTRL);
  assign wr_cfg    = wr_any & addr_hit(bus_addr, A_CFG);
  assign wr_ien    = wr_any & addr_hit(bus_addr, A_IEN);
  assign wr_iclr   = wr_any & addr_hit(bus_addr, A_ICLR);
  assign wr_reload = wr_any & addr_hit(bus_addr, A_RELOAD);
  assign clr_evt   = wr_iclr & bus_wdata[FLAG_BIT];

  // start commands need the enable bit in the same write; continuous wins over single
  always_comb begin
    cmd_o.halt = wr_ctrl & ~bus_wdata[CTRL_EN_BIT];
    cmd_o.loop = wr_ctrl &  bus_wdata[CTRL_EN_BIT] & bus_wdata[CTRL_LOOP_BIT];
    cmd_o.once = wr_ctrl &  bus_wdata[CTRL_EN_BIT] & bus_wdata[CTRL_ONCE_BIT]
                         & ~bus_wdata[CTRL_LOOP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      div_q    <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl)             en_q     <= bus_wdata[CTRL_EN_BIT];
      if (wr_cfg)              div_q    <= bus_wdata[CFG_DIV_LSB +: PSC_W];
      if (wr_ien && !en_q)     ie_q     <= bus_wdata[FLAG_BIT];
      if (wr_reload && en_q)   reload_q <= bus_wdata[CNT_W-1:0];
      // a match in the same cycle as a clear keeps the flag set
      if (match_evt_i)         flag_q   <= 1'b1;
      else if (clr_evt)        flag_q   <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(A_CTRL):   bus_rdata[CTRL_EN_BIT] = en_q;
      ADDR_W'(A_CFG):    bus_rdata[CFG_DIV_LSB +: PSC_W] = div_q;
      ADDR_W'(A_IEN):    bus_rdata[FLAG_BIT] = ie_q;
      ADDR_W'(A_STAT):   bus_rdata[FLAG_BIT] = flag_q;
      ADDR_W'(A_RELOAD): bus_rdata[CNT_W-1:0] = reload_q;
      default:           bus_rdata = '0;
    endcase
  end

  assign en_o      = en_q;
  assign div_sel_o = div_q;
  assign reload_o  = reload_q;
  assign irq_o     = flag_q & ie_q;

  AST_IEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(ie_q)); // R5
  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(reload_q)); // R6
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt_i |=> flag_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_evt) |=> flag_q); // R8

endmodule

// File: rtl/ewt_prescaler.sv
module ewt_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] div_sel_i,
  output logic             tick_o
);

  localparam int PH_W = (1 << PSC_W) - 1;

  logic [PH_W-1:0] phase_q;

  // last phase of a divide-by-2^sel period
  function automatic logic [PH_W-1:0] last_phase(input logic [PSC_W-1:0] sel);
    logic [PH_W:0] one_hot;
    one_hot = (PH_W+1)'(1) << sel;
    return PH_W'(one_hot - 1'b1);
  endfunction

  // >= keeps a divider change during a run from stalling the tick
  assign tick_o = run_i & (phase_q >= last_phase(div_sel_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         phase_q <= '0;
    else if (clr_i || !run_i || tick_o) phase_q <= '0;
    else                                phase_q <= phase_q + 1'b1;
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> phase_q == '0); // R2

endmodule

// File: rtl/ewt_counter.sv
module ewt_counter
  import ewt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ewt_cmd_t         cmd_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             running_o,
  output logic             restart_o,
  output logic             match_evt_o
);

  logic             running_q;
  logic             loop_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_req;
  logic             reload_zero;
  logic             at_top;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic wrap);
    return wrap ? '0 : c + 1'b1;
  endfunction

  assign start_req   = cmd_i.once | cmd_i.loop;
  assign reload_zero = (reload_i == '0);
  assign at_top      = (cnt_q == reload_i);
  assign restart_o   = start_req | cmd_i.halt;
  assign match_evt_o = running_q & tick_i & at_top & ~reload_zero & ~restart_o;
  assign running_o   = running_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      loop_q    <= 1'b0;
      cnt_q     <= '0;
    end else if (cmd_i.halt || (start_req && reload_zero)) begin
      running_q <= 1'b0;
      loop_q    <= 1'b0;
      cnt_q     <= '0;
    end else if (start_req) begin
      running_q <= 1'b1;
      loop_q    <= cmd_i.loop;
      cnt_q     <= '0;
    end else if (running_q) begin
      if (reload_zero) begin
        running_q <= 1'b0;
        cnt_q     <= '0;
      end else if (tick_i) begin
        cnt_q <= step(cnt_q, at_top);
        if (at_top && !loop_q) running_q <= 1'b0;
      end
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt_o |=> cnt_q == '0); // R3
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt_o && !loop_q) |=> !running_q); // R4
  AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && reload_zero) |=> !running_q); // R10

endmodule

// File: rtl/evt_wake_timer.sv
module evt_wake_timer
  import ewt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int PSC_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  ewt_cmd_t         cmd;
  logic             timer_en;
  logic [PSC_W-1:0] div_sel;
  logic [CNT_W-1:0] reload;
  logic             running;
  logic             restart;
  logic             tick;
  logic             match_evt;

  ewt_regs #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .PSC_W (PSC_W),
    .ADDR_W(ADDR_W)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .match_evt_i(match_evt),
    .cmd_o      (cmd),
    .en_o       (timer_en),
    .div_sel_o  (div_sel),
    .reload_o   (reload),
    .irq_o      (irq)
  );

  ewt_prescaler #(
    .PSC_W(PSC_W)
  ) i_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (running),
    .clr_i    (restart),
    .div_sel_i(div_sel),
    .tick_o   (tick)
  );

  ewt_counter #(
    .CNT_W(CNT_W)
  ) i_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd),
    .tick_i     (tick),
    .reload_i   (reload),
    .running_o  (running),
    .restart_o  (restart),
    .match_evt_o(match_evt)
  );

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_en |-> !running); // R9
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> (timer_en && tick)); // R2

endmodule

// File: tb/test_evt_wake_timer.sv
module test_evt_wake_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {divider N, reload, expected edges from start write to first match}
  localparam logic [39:0] VECS [NVEC] = '{
    {4'd0, 16'd1, 20'd2},
    {4'd0, 16'd5, 20'd6},
    {4'd1, 16'd3, 20'd8},
    {4'd2, 16'd2, 20'd12},
    {4'd5, 16'd4, 20'd160},
    {4'd7, 16'd1, 20'd256}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int tests = 0;
  int fails = 0;

  evt_wake_timer i_evt_wake_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge; returns at a negedge
  task automatic bus_write(input int a, input int d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    bus_addr = 3'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int lim, output int k);
    k = 0;
    while (!irq && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    int v;
    int k;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state, R11 map
    for (int a = 0; a < 8; a++) begin
      bus_read(a, v);
      check_eq($sformatf("R1 reset read addr %0d", a), v, 0);
    end
    check_eq("R1 irq low after reset", int'(irq), 0);

    // R2 vector table: divider and reload against first-match latency
    for (int i = 0; i < NVEC; i++) begin
      int n, rl, lat;
      n = int'(VECS[i][39:36]); rl = int'(VECS[i][35:20]); lat = int'(VECS[i][19:0]);
      bus_write(0, 0);
      bus_write(3, 1);
      bus_write(2, 1);
      bus_write(1, n << 9);
      bus_write(0, 1);
      bus_write(5, rl);
      bus_write(0, 3);
      wait_irq(lat + 20, k);
      check_eq($sformatf("R2 first match latency div=%0d reload=%0d", n, rl), k, lat);
      bus_read(1, v);
      check_eq("R11 divider field at [11:9]", v, n << 9);
      if (i == 0) begin
        bus_read(0, v);
        check_eq("R10 start bits read back as 0", v, 1);
      end
    end

    // R8 level hold, R7 clear semantics
    idle(10);
    check_eq("R8 irq held until clear", int'(irq), 1);
    bus_write(3, 0);
    bus_read(4, v);
    check_eq("R7 clear with 0 has no effect", v, 1);
    bus_write(3, 1);
    bus_read(4, v);
    check_eq("R7 clear with 1 drops flag", v, 0);
    check_eq("R8 irq low after clear", int'(irq), 0);

    // R4 single shot stopped
    idle(600);
    check_eq("R4 single shot gives one match only", int'(irq), 0);

    // R3 continuous mode
    bus_write(0, 0);
    bus_write(1, 0);
    bus_write(0, 1);
    bus_write(5, 3);
    bus_write(0, 5);
    wait_irq(40, k);
    check_eq("R3 continuous first period", k, 4);
    bus_write(3, 1);
    wait_irq(40, k);
    check_eq("R3 continuous next match after clear", k, 3);

    // R7 clear lands on the next match edge: set wins
    idle(3);
    bus_write(3, 1);
    bus_read(4, v);
    check_eq("R7 match and clear in same cycle keep flag", v, 1);

    // R5 interrupt enable locked while enabled
    bus_write(2, 0);
    bus_read(2, v);
    check_eq("R5 enable write ignored while running", v, 1);
    check_eq("R5 irq still high", int'(irq), 1);

    // R9 stop keeps flag; R8 mask
    bus_write(0, 0);
    bus_read(4, v);
    check_eq("R9 stop keeps match flag", v, 1);
    bus_write(2, 0);
    check_eq("R8 irq masked by enable", int'(irq), 0);
    bus_read(4, v);
    check_eq("R8 flag unaffected by mask", v, 1);
    bus_write(3, 1);

    // R6 reload locked while disabled
    bus_write(5, 7);
    bus_read(5, v);
    check_eq("R6 reload write ignored while disabled", v, 3);

    // R9 stop resets counter and prescaler
    bus_write(2, 1);
    bus_write(0, 1);
    bus_write(5, 9);
    bus_write(0, 5);
    idle(5);
    bus_write(0, 0);
    bus_write(0, 1);
    bus_write(0, 5);
    wait_irq(60, k);
    check_eq("R9 restart after stop counts full period", k, 10);

    // R10 reload zero and start without enable are ignored
    bus_write(0, 0);
    bus_write(3, 1);
    bus_write(0, 1);
    bus_write(5, 0);
    bus_write(0, 3);
    idle(50);
    check_eq("R10 reload zero does not start", int'(irq), 0);
    bus_read(4, v);
    check_eq("R10 no flag with reload zero", v, 0);
    bus_write(5, 2);
    bus_write(0, 2);
    idle(20);
    check_eq("R10 start without enable ignored", int'(irq), 0);
    bus_read(0, v);
    check_eq("R10 control reads disabled", v, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule